// File: doc/BRIEF.md
# Thermostat Alert Engine with Consecutive-Fault Filter

This block sits behind a temperature converter. Every time a new 12-bit two's-complement reading arrives, it compares the reading with a high threshold and a low threshold and decides whether the alert line should change. A filter depth of 1, 2, 4 or 6 sets how many back-to-back offending readings are needed before any change is made. This keeps single noisy samples from toggling the line.

Two behaviours can be selected. In level (comparator) mode the alert follows the temperature with hysteresis. In event (interrupt) mode the alert latches and stays set until software acknowledges it. Event mode alternates between watching the high threshold and watching the low threshold. The electrical sense of the output pin is programmable. A flag records which threshold caused the most recent assertion, so that an alert-response reply can report it. A bus-wide reset command returns the engine to its idle state.

Top module: `thermo_alert`

## Requirements
- R1: After rst_n is released the alert is inactive: alert_out is 1 when pol_high is 0, and alert_src is 0.
- R2: The filter code qdepth selects how many consecutive offending readings are needed before the alert changes: 0 needs 1, 1 needs 2, 2 needs 4, 3 needs 6. A reading counts only in a cycle where conv_done is 1.
- R3: A reading that does not offend against the condition currently being watched restarts the consecutive count from zero.
- R4: The high test is signed two's complement over all 12 bits: a reading offends when temp >= lim_hi, and a difference in the lowest bit of lim_hi alone decides the outcome.
- R5: In level mode (irq_mode = 0) an active alert is released after the filtered number of readings with temp < lim_lo. Readings at or above lim_lo keep it active.
- R6: In level mode the acknowledge inputs ack_read, ack_resp and ack_sleep have no effect on the alert.
- R7: In event mode (irq_mode = 1) the alert asserts after the filtered number of readings at or above lim_hi. Any one of ack_read, ack_resp or ack_sleep releases it in the next cycle.
- R8: In event mode, after a high-threshold alert is released, only readings below lim_lo (filtered) can raise the next alert. Once that alert is released, the engine watches lim_hi again.
- R9: In event mode an active alert ignores new readings of any value until it is acknowledged. An acknowledge in the same cycle as a reading discards that reading.
- R10: pol_high = 0 drives alert_out low while active. pol_high = 1 drives it high while active. The change takes effect combinationally.
- R11: alert_src is set to 1 when an alert is raised by the high threshold and to 0 when an alert is raised by the low threshold.
- R12: A one-cycle gc_reset makes the alert inactive, clears alert_src and the consecutive count, and re-arms event mode on the high threshold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| conv_done | input | 1 | One-cycle strobe: a new reading is on temp |
| temp | input | 12 | Reading, signed two's complement, 1/16 degree per LSB |
| lim_hi | input | 12 | High threshold, signed |
| lim_lo | input | 12 | Low threshold, signed |
| irq_mode | input | 1 | 0 = level (comparator) mode, 1 = event (interrupt) mode |
| pol_high | input | 1 | 1 = alert_out active high, 0 = active low |
| qdepth | input | 2 | Filter code selecting 1, 2, 4 or 6 consecutive readings |
| ack_read | input | 1 | Any register was read |
| ack_resp | input | 1 | Alert-response arbitration was won |
| ack_sleep | input | 1 | Converter entered shutdown |
| gc_reset | input | 1 | Bus-wide reset command |
| alert_out | output | 1 | Alert pin level |
| alert_src | output | 1 | 1 if the latest alert came from the high threshold, 0 if from the low |

## Verification
The bench targets the filter length at each of the four codes. A counter that is off by one asserts one reading early or late. It also feeds a non-offending reading into the middle of a run; a design that failed to restart the count would assert early. The high threshold is placed at a negative value against a large positive reading, so an unsigned compare would miss the fault. A single-LSB threshold step catches a compare that drops the low bits. In event mode the bench checks the alternation sequence and the source flag. A design that re-armed on the high threshold after an acknowledge would raise a second high alert where none belongs.

// File: rtl/thermo_alert_pkg.sv
package thermo_alert_pkg;

    localparam int TEMP_W  = 12;
    localparam int QCODE_W = 2;
    localparam int CNT_W   = 3;

    // Architectural state of the alert engine
    typedef struct packed {
        logic active;     // logical alert, before polarity
        logic armed_low;  // event mode: 1 = watching the low threshold
        logic src_hi;     // cause of the latest assertion
    } alert_state_t;

    // Number of consecutive offending readings demanded by a filter code
    function automatic logic [CNT_W-1:0] run_length(input logic [QCODE_W-1:0] code);
        logic [CNT_W-1:0] n;
        case (code)
            2'd0:    n = 3'd1;
            2'd1:    n = 3'd2;
            2'd2:    n = 3'd4;
            default: n = 3'd6;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/thr_cmp.sv
module thr_cmp #(
    parameter int TW    = 12,
    parameter bit ABOVE = 1'b1
) (
    input  logic signed [TW-1:0] value,
    input  logic signed [TW-1:0] limit,
    output logic                 hit
);
    generate
        if (ABOVE) begin : g_at_or_above
            assign hit = (value >= limit);
        end else begin : g_below
            assign hit = (value < limit);
        end
    endgenerate
endmodule

// File: rtl/fault_run.sv
module fault_run #(
    parameter int CW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          strobe,
    input  logic          fault,
    input  logic          flush,
    input  logic [CW-1:0] need,
    output logic          reach
);
    localparam int EW = CW + 1;

    logic [CW-1:0] cnt_d, cnt_q;
    logic [EW-1:0] cnt_inc;

    always_comb begin
        cnt_inc = {1'b0, cnt_q} + EW'(1);
        reach   = strobe && fault && !flush && (cnt_inc >= {1'b0, need});
        cnt_d   = cnt_q;
        if (flush || reach || (strobe && !fault)) begin
            cnt_d = '0;
        end else if (strobe && fault) begin
            cnt_d = cnt_inc[CW-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end
endmodule

// File: rtl/thermo_alert.sv
module thermo_alert
    import thermo_alert_pkg::*;
#(
    parameter int TW = TEMP_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          conv_done,
    input  logic [TW-1:0] temp,
    input  logic [TW-1:0] lim_hi,
    input  logic [TW-1:0] lim_lo,
    input  logic          irq_mode,
    input  logic          pol_high,
    input  logic [1:0]    qdepth,
    input  logic          ack_read,
    input  logic          ack_resp,
    input  logic          ack_sleep,
    input  logic          gc_reset,
    output logic          alert_out,
    output logic          alert_src
);
    localparam int NCMP = 2;

    alert_state_t st_d, st_q;

    logic [NCMP-1:0]     cmp_hit;   // [1] at/above high, [0] below low
    logic [TW-1:0]       cmp_lim [NCMP];
    logic                watch_low;
    logic                fault;
    logic                any_ack;
    logic                ack_take;
    logic                flush;
    logic                reach;
    logic [CNT_W-1:0]    need;

    assign cmp_lim[0] = lim_lo;
    assign cmp_lim[1] = lim_hi;

    generate
        for (genvar i = 0; i < NCMP; i++) begin : g_cmp
            thr_cmp #(.TW(TW), .ABOVE(i == 1)) u_cmp (
                .value (temp),
                .limit (cmp_lim[i]),
                .hit   (cmp_hit[i])
            );
        end
    endgenerate

    always_comb begin
        any_ack   = ack_read || ack_resp || ack_sleep;
        ack_take  = irq_mode && st_q.active && any_ack;
        // level mode watches low while active; event mode follows its arm
        watch_low = irq_mode ? st_q.armed_low : st_q.active;
        fault     = watch_low ? cmp_hit[0] : cmp_hit[1];
        // latched event alerts and bus resets freeze the filter
        flush     = gc_reset || (irq_mode && st_q.active);
        need      = run_length(qdepth);
    end

    fault_run #(.CW(CNT_W)) u_run (
        .clk    (clk),
        .rst_n  (rst_n),
        .strobe (conv_done),
        .fault  (fault),
        .flush  (flush),
        .need   (need),
        .reach  (reach)
    );

    always_comb begin
        st_d = st_q;
        if (gc_reset) begin
            st_d = '0;
        end else if (ack_take) begin
            st_d.active = 1'b0;
        end else if (reach) begin
            if (irq_mode) begin
                st_d.active    = 1'b1;
                st_d.src_hi    = !st_q.armed_low;
                st_d.armed_low = !st_q.armed_low;
            end else begin
                st_d.active = !st_q.active;
                if (!st_q.active) begin
                    st_d.src_hi = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign alert_out = pol_high ? st_q.active : !st_q.active;
    assign alert_src = st_q.src_hi;

endmodule

// File: rtl/thermo_alert_chk.sv
module thermo_alert_chk (
    input logic clk,
    input logic rst_n,
    input logic conv_done,
    input logic irq_mode,
    input logic pol_high,
    input logic ack_read,
    input logic ack_resp,
    input logic ack_sleep,
    input logic gc_reset,
    input logic alert_out,
    input logic alert_src
);
    logic lvl;
    logic acks;
    assign lvl  = pol_high ? alert_out : !alert_out;
    assign acks = ack_read || ack_resp || ack_sleep;

    // R9: outside readings, acknowledges and resets the logical alert holds
    a_r9_hold_without_event: assert property (@(posedge clk) disable iff (!rst_n)
        (!conv_done && !gc_reset && !(irq_mode && acks)) |=> $stable(lvl));

    // R7: an acknowledge in event mode releases an active alert
    a_r7_ack_releases: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_mode && lvl && acks && !gc_reset) |=> !lvl);

    // R12: bus reset leaves the alert inactive with the source flag clear
    a_r12_gc_idle: assert property (@(posedge clk) disable iff (!rst_n)
        gc_reset |=> (!lvl && !alert_src));

    // R2: an assertion is always the result of a reading
    a_r2_rise_needs_reading: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(lvl) && $stable(pol_high)) |-> $past(conv_done));

    // R11: level-mode assertions always report the high threshold
    a_r11_level_src_high: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(lvl) && $stable(pol_high) && $past(!irq_mode)) |-> alert_src);
endmodule

bind thermo_alert thermo_alert_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .conv_done (conv_done),
    .irq_mode  (irq_mode),
    .pol_high  (pol_high),
    .ack_read  (ack_read),
    .ack_resp  (ack_resp),
    .ack_sleep (ack_sleep),
    .gc_reset  (gc_reset),
    .alert_out (alert_out),
    .alert_src (alert_src)
);

// File: tb/thermo_alert_test.sv
module thermo_alert_test;
    localparam time CLK_PERIOD = 10ns;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        conv_done = 1'b0;
    logic [11:0] temp = '0;
    logic [11:0] lim_hi = 12'h500;
    logic [11:0] lim_lo = 12'h4B0;
    logic        irq_mode = 1'b0;
    logic        pol_high = 1'b0;
    logic [1:0]  qdepth = 2'd0;
    logic        ack_read = 1'b0;
    logic        ack_resp = 1'b0;
    logic        ack_sleep = 1'b0;
    logic        gc_reset = 1'b0;
    logic        alert_out;
    logic        alert_src;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    thermo_alert uut (
        .clk(clk), .rst_n(rst_n), .conv_done(conv_done), .temp(temp),
        .lim_hi(lim_hi), .lim_lo(lim_lo), .irq_mode(irq_mode),
        .pol_high(pol_high), .qdepth(qdepth), .ack_read(ack_read),
        .ack_resp(ack_resp), .ack_sleep(ack_sleep), .gc_reset(gc_reset),
        .alert_out(alert_out), .alert_src(alert_src)
    );

    function automatic logic level();
        return pol_high ? alert_out : !alert_out;
    endfunction

    task automatic chk(input string req, input string what, input logic got, input logic exp);
        n_vec++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s %s: got %0b expected %0b", req, what, got, exp);
        end
    endtask

    task automatic push(input logic [11:0] t);
        @(negedge clk);
        conv_done = 1'b1;
        temp = t;
        @(negedge clk);
        conv_done = 1'b0;
    endtask

    task automatic pulse_ack(input int which);
        @(negedge clk);
        ack_read  = (which == 0);
        ack_resp  = (which == 1);
        ack_sleep = (which == 2);
        @(negedge clk);
        ack_read = 1'b0; ack_resp = 1'b0; ack_sleep = 1'b0;
    endtask

    task automatic bus_reset();
        @(negedge clk);
        gc_reset = 1'b1;
        @(negedge clk);
        gc_reset = 1'b0;
    endtask

    task automatic t_reset_state();
        chk("R1", "alert_out idle", alert_out, 1'b1);
        chk("R1", "alert_src idle", alert_src, 1'b0);
    endtask

    task automatic t_level_hysteresis();
        bus_reset();
        irq_mode = 0; qdepth = 0;
        push(12'h500);
        chk("R4", "assert at high limit", level(), 1'b1);
        chk("R11", "src high", alert_src, 1'b1);
        push(12'h4C0);
        chk("R5", "hold between limits", level(), 1'b1);
        push(12'h4B0);
        chk("R5", "hold at low limit", level(), 1'b1);
        push(12'h4AF);
        chk("R5", "release below low", level(), 1'b0);
    endtask

    task automatic t_signed_and_lsb();
        bus_reset();
        lim_hi = 12'hFF0; lim_lo = 12'hFE0;
        push(12'h7F0);
        chk("R4", "positive above negative limit", level(), 1'b1);
        push(12'h800);
        chk("R5", "most negative below low", level(), 1'b0);
        lim_hi = 12'h501; lim_lo = 12'h4B0;
        push(12'h500);
        chk("R4", "one LSB under high", level(), 1'b0);
        push(12'h501);
        chk("R4", "exactly high LSB", level(), 1'b1);
        lim_hi = 12'h500;
    endtask

    task automatic t_filter_depths();
        int runs [4] = '{1, 2, 4, 6};
        for (int c = 0; c < 4; c++) begin
            bus_reset();
            irq_mode = 0; qdepth = c[1:0];
            for (int k = 0; k < runs[c] - 1; k++) push(12'h600);
            chk("R2", $sformatf("code %0d one short", c), level(), 1'b0);
            push(12'h600);
            chk("R2", $sformatf("code %0d full run", c), level(), 1'b1);
        end
        bus_reset();
        qdepth = 2'd2;
        for (int k = 0; k < 3; k++) push(12'h600);
        push(12'h100);
        for (int k = 0; k < 3; k++) push(12'h600);
        chk("R3", "run restarted by good reading", level(), 1'b0);
        push(12'h600);
        chk("R3", "fourth of new run asserts", level(), 1'b1);
        qdepth = 0;
    endtask

    task automatic t_level_ignores_acks();
        bus_reset();
        irq_mode = 0; qdepth = 0;
        push(12'h600);
        for (int w = 0; w < 3; w++) begin
            pulse_ack(w);
            chk("R6", $sformatf("ack %0d in level mode", w), level(), 1'b1);
        end
    endtask

    task automatic t_event_cycle();
        bus_reset();
        irq_mode = 1; qdepth = 0;
        push(12'h500);
        chk("R7", "event assert on high", level(), 1'b1);
        chk("R11", "src high", alert_src, 1'b1);
        push(12'h100);
        chk("R9", "active ignores low reading", level(), 1'b1);
        pulse_ack(0);
        chk("R7", "read releases", level(), 1'b0);
        push(12'h600);
        chk("R8", "high ignored while armed low", level(), 1'b0);
        push(12'h4AF);
        chk("R8", "low raises alert", level(), 1'b1);
        chk("R11", "src low", alert_src, 1'b0);
        pulse_ack(1);
        chk("R7", "alert response releases", level(), 1'b0);
        push(12'h400);
        chk("R8", "low ignored after re-arm", level(), 1'b0);
        push(12'h500);
        chk("R8", "high armed again", level(), 1'b1);
        chk("R11", "src high again", alert_src, 1'b1);
        // acknowledge and reading together: reading dropped
        @(negedge clk);
        ack_sleep = 1'b1; conv_done = 1'b1; temp = 12'h100;
        @(negedge clk);
        ack_sleep = 1'b0; conv_done = 1'b0;
        chk("R7", "shutdown releases", level(), 1'b0);
        push(12'h100);
        chk("R9", "discarded reading not counted", level(), 1'b1);
    endtask

    task automatic t_polarity();
        bus_reset();
        irq_mode = 0; qdepth = 0;
        pol_high = 1'b1; #1;
        chk("R10", "inactive active-high pin", alert_out, 1'b0);
        push(12'h600);
        chk("R10", "active active-high pin", alert_out, 1'b1);
        pol_high = 1'b0; #1;
        chk("R10", "active active-low pin", alert_out, 1'b0);
    endtask

    task automatic t_bus_reset();
        bus_reset();
        irq_mode = 1; qdepth = 0;
        push(12'h600);
        pulse_ack(0);
        bus_reset();
        chk("R12", "inactive after reset", level(), 1'b0);
        chk("R12", "src cleared", alert_src, 1'b0);
        push(12'h600);
        chk("R12", "re-armed on high", level(), 1'b1);
        pulse_ack(0);
        bus_reset();
        irq_mode = 0; qdepth = 2'd2;
        for (int k = 0; k < 3; k++) push(12'h600);
        bus_reset();
        push(12'h600);
        chk("R12", "count cleared", level(), 1'b0);
        qdepth = 0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_state();
        t_level_hysteresis();
        t_signed_and_lsb();
        t_filter_depths();
        t_level_ignores_acks();
        t_event_cycle();
        t_polarity();
        t_bus_reset();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            done = 1'b1;
            n_vec++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule